// File: doc/BRIEF.md
# ADC Event Control Unit

This block holds the event settings for up to four converter instances. For each instance, one small configuration register decides three things: whether a start-of-conversion trigger from the event fabric is passed to the converter, whether that trigger is inverted first, and whether the converter core's result-ready and window-match strobes go out as event pulses. A simple register bus reads and writes the four registers. The register of an instance is locked while that instance is enabled.

Each raw start input goes through a two-stage synchronizer. The optional inversion is then applied. A three-state edge machine per instance turns each rising edge of the resulting level into exactly one conversion-start pulse. The states are ARM, LOW and HIGH, and the transitions are:

- REARM: from any state to ARM, on reset or when the register of that instance is written.
- SETTLE_HIGH: from ARM to HIGH when the level is high.
- SETTLE_LOW: from ARM to LOW when the level is low.
- FIRE: from LOW to HIGH when the level rises. This is the only transition that can issue a start.
- RELEASE: from HIGH to LOW when the level falls.

Because ARM only samples the level, a reset or a new setting never produces a start by itself.

Top module: `adc_evt_ctrl`

## Requirements
- R1: After reset every configuration register reads 0, and conv_start, res_evt, win_evt and bus_rsp_vld are all low.
- R2: Instance n is addressed at byte offset 0x3C + n*0x20. Its fields are: bit 0 start-trigger enable, bit 3 start invert, bit 4 result-event enable, bit 5 window-event enable. Every access gets bus_rsp_vld, bus_rdata and bus_err one cycle after bus_sel.
- R3: Bits 1, 2 and 6 to 31 are not stored: writes to them have no effect and they read as zero.
- R4: A write to instance n while inst_enable[n] is 1 returns bus_err = 1, and the stored value stays unchanged.
- R5: A read is accepted with bus_err = 0 whatever the value of inst_enable. An access to any other offset, including a misaligned one, returns bus_err = 1.
- R6: When bit 0 is 0, conv_start of that instance stays low for any start input.
- R7: With bit 0 set and bit 3 clear, a rising edge on start_raw gives one conv_start pulse of one cycle, three cycles after the input changes. A held high level and a falling edge give none.
- R8: With bit 3 set, a falling edge of start_raw starts a conversion and a rising edge does not. Writing the register re-arms the detector, so the new setting alone never issues a start.
- R9: When bit 4 is set, each cycle of res_rdy gives a one-cycle res_evt pulse on the next cycle. When bit 4 is clear, res_evt stays low.
- R10: When bit 5 is set, each cycle of win_match gives a one-cycle win_evt pulse on the next cycle. When bit 5 is clear, win_evt stays low.
- R11: The instances are independent: the settings and strobes of one instance never affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rsp_vld | output | 1 | Response valid, one cycle after bus_sel |
| bus_rdata | output | 32 | Read data, valid with bus_rsp_vld |
| bus_err | output | 1 | Error response (locked write or unmapped offset) |
| inst_enable | input | NUM_INST | Global enable of each converter instance |
| start_raw | input | NUM_INST | Asynchronous start-trigger event per instance |
| conv_start | output | NUM_INST | One-cycle conversion-start pulse per instance |
| res_rdy | input | NUM_INST | Result-available strobe from each converter core |
| win_match | input | NUM_INST | Window-compare strobe from each converter core |
| res_evt | output | NUM_INST | Result-ready event pulse |
| win_evt | output | NUM_INST | Window event pulse |

## Verification
Each output has a fixed latency:

- A bus response arrives one cycle after the request.
- An event pulse arrives one cycle after its strobe.
- A conversion start arrives three cycles after the raw input changes: two synchronizer stages, then the edge register.
- A register write re-arms the detector at the write edge, and the detector settles one cycle later.

The bench drives every input on a falling edge and samples on the falling edge of the exact cycle a result is due. For each trigger stimulus it checks conv_start on every cycle of a six-cycle window. That proves the pulse appears in cycle three only and that absent pulses stay absent.

// File: rtl/adc_evt_pkg.sv
package adc_evt_pkg;

    localparam int REG_W = 32;

    // Bit positions of the stored fields inside the bus word
    localparam int BIT_START_EN = 0;
    localparam int BIT_INV      = 3;
    localparam int BIT_RES_OE   = 4;
    localparam int BIT_WIN_OE   = 5;

    typedef struct packed {
        logic win_oe;
        logic res_oe;
        logic start_inv;
        logic start_en;
    } evt_cfg_t;

    typedef enum logic [1:0] {
        EDGE_ARM  = 2'd0,
        EDGE_LOW  = 2'd1,
        EDGE_HIGH = 2'd2
    } edge_st_t;

    function automatic logic [REG_W-1:0] cfg_to_word(input evt_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[BIT_START_EN] = c.start_en;
        w[BIT_INV]      = c.start_inv;
        w[BIT_RES_OE]   = c.res_oe;
        w[BIT_WIN_OE]   = c.win_oe;
        return w;
    endfunction

endpackage

// File: rtl/adc_evt_regs.sv
module adc_evt_regs
    import adc_evt_pkg::*;
#(
    parameter int NUM_INST    = 4,
    parameter int ADDR_W      = 8,
    parameter int BASE_OFS    = 32'h3C,
    parameter int INST_STRIDE = 32'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    input  logic [NUM_INST-1:0] inst_enable,
    output logic                bus_rsp_vld,
    output logic [REG_W-1:0]    bus_rdata,
    output logic                bus_err,
    output evt_cfg_t            cfg_o [NUM_INST],
    output logic [NUM_INST-1:0] cfg_wr_o
);

    logic [NUM_INST-1:0] hit;
    logic                any_hit;
    logic                locked;
    logic [REG_W-1:0]    rd_word;
    evt_cfg_t            cfg_q [NUM_INST];

    // Address decode: one exact-match comparator per instance
    always_comb begin
        hit     = '0;
        rd_word = '0;
        for (int i = 0; i < NUM_INST; i++) begin
            hit[i] = (bus_addr == ADDR_W'(BASE_OFS + i * INST_STRIDE));
            if (hit[i]) begin
                rd_word = rd_word | cfg_to_word(cfg_q[i]);
            end
        end
        any_hit = |hit;
        locked  = |(hit & inst_enable);
    end

    assign cfg_wr_o = hit & ~inst_enable & {NUM_INST{bus_sel & bus_wr}};

    generate
        for (genvar g = 0; g < NUM_INST; g++) begin : g_cfg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q[g] <= '0;
                end else if (cfg_wr_o[g]) begin
                    cfg_q[g].start_en  <= bus_wdata[BIT_START_EN];
                    cfg_q[g].start_inv <= bus_wdata[BIT_INV];
                    cfg_q[g].res_oe    <= bus_wdata[BIT_RES_OE];
                    cfg_q[g].win_oe    <= bus_wdata[BIT_WIN_OE];
                end
            end
            assign cfg_o[g] = cfg_q[g];
        end
    endgenerate

    // Registered response stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rsp_vld <= 1'b0;
            bus_err     <= 1'b0;
            bus_rdata   <= '0;
        end else begin
            bus_rsp_vld <= bus_sel;
            if (bus_sel) begin
                bus_err   <= !any_hit || (bus_wr && locked);
                bus_rdata <= (!bus_wr && any_hit) ? rd_word : '0;
            end else begin
                bus_err   <= 1'b0;
                bus_rdata <= '0;
            end
        end
    end

endmodule

// File: rtl/adc_evt_start.sv
module adc_evt_start
    import adc_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic trig_en,
    input  logic trig_inv,
    input  logic rearm,
    output logic start_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic                   start_q;
    edge_st_t               st_q;
    edge_st_t               st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
        end
    end

    assign lvl = sync_q[SYNC_STAGES-1] ^ trig_inv;

    // Next state
    always_comb begin
        st_d = st_q;
        if (rearm) begin
            st_d = EDGE_ARM;                          // REARM
        end else begin
            unique case (st_q)
                EDGE_ARM:  st_d = lvl ? EDGE_HIGH : EDGE_LOW; // SETTLE_HIGH / SETTLE_LOW
                EDGE_LOW:  if (lvl)  st_d = EDGE_HIGH;        // FIRE
                EDGE_HIGH: if (!lvl) st_d = EDGE_LOW;         // RELEASE
                default:   st_d = EDGE_ARM;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= EDGE_ARM;
        end else begin
            st_q <= st_d;
        end
    end

    // Output register: a start only on the FIRE transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= !rearm && trig_en && (st_q == EDGE_LOW) && lvl;
        end
    end

    assign start_o = start_q;

endmodule

// File: rtl/adc_evt_out.sv
module adc_evt_out (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic out_en,
    output logic pulse_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= strobe && out_en;
        end
    end

endmodule

// File: rtl/adc_evt_ctrl.sv
module adc_evt_ctrl
    import adc_evt_pkg::*;
#(
    parameter int NUM_INST    = 4,
    parameter int ADDR_W      = 8,
    parameter int BASE_OFS    = 32'h3C,
    parameter int INST_STRIDE = 32'h20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic                bus_rsp_vld,
    output logic [31:0]         bus_rdata,
    output logic                bus_err,
    input  logic [NUM_INST-1:0] inst_enable,
    input  logic [NUM_INST-1:0] start_raw,
    output logic [NUM_INST-1:0] conv_start,
    input  logic [NUM_INST-1:0] res_rdy,
    input  logic [NUM_INST-1:0] win_match,
    output logic [NUM_INST-1:0] res_evt,
    output logic [NUM_INST-1:0] win_evt
);

    localparam int CFG_W = $bits(evt_cfg_t);

    evt_cfg_t                  cfg [NUM_INST];
    logic [NUM_INST-1:0]       cfg_wr;
    logic [CFG_W*NUM_INST-1:0] cfg_flat;

    adc_evt_regs #(
        .NUM_INST    (NUM_INST),
        .ADDR_W      (ADDR_W),
        .BASE_OFS    (BASE_OFS),
        .INST_STRIDE (INST_STRIDE)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .inst_enable (inst_enable),
        .bus_rsp_vld (bus_rsp_vld),
        .bus_rdata   (bus_rdata),
        .bus_err     (bus_err),
        .cfg_o       (cfg),
        .cfg_wr_o    (cfg_wr)
    );

    generate
        for (genvar g = 0; g < NUM_INST; g++) begin : g_inst
            assign cfg_flat[g*CFG_W +: CFG_W] = cfg[g];

            adc_evt_start #(
                .SYNC_STAGES (SYNC_STAGES)
            ) start_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .raw_in   (start_raw[g]),
                .trig_en  (cfg[g].start_en),
                .trig_inv (cfg[g].start_inv),
                .rearm    (cfg_wr[g]),
                .start_o  (conv_start[g])
            );

            adc_evt_out res_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .strobe  (res_rdy[g]),
                .out_en  (cfg[g].res_oe),
                .pulse_o (res_evt[g])
            );

            adc_evt_out win_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .strobe  (win_match[g]),
                .out_en  (cfg[g].win_oe),
                .pulse_o (win_evt[g])
            );
        end
    endgenerate

endmodule

// File: rtl/adc_evt_ctrl_chk.sv
module adc_evt_ctrl_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_sel,
    input logic           bus_rsp_vld,
    input logic           bus_err,
    input logic [31:0]    bus_rdata,
    input logic [N-1:0]   inst_enable,
    input logic [N-1:0]   res_rdy,
    input logic [N-1:0]   win_match,
    input logic [N-1:0]   conv_start,
    input logic [N-1:0]   res_evt,
    input logic [N-1:0]   win_evt,
    input logic [4*N-1:0] cfg_flat
);

    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rsp_vld == $past(bus_sel));

    // R3
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rsp_vld && !bus_err) |-> (bus_rdata[31:6] == '0 && bus_rdata[2:1] == '0));

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            // R4
            locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                inst_enable[i] |=> $stable(cfg_flat[4*i +: 4]));

            // R6
            start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                conv_start[i] |-> $past(cfg_flat[4*i]));

            // R7
            start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                conv_start[i] |=> !conv_start[i]);

            // R9
            res_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
                res_evt[i] |-> $past(res_rdy[i] && cfg_flat[4*i+2]));

            // R10
            win_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
                win_evt[i] |-> $past(win_match[i] && cfg_flat[4*i+3]));
        end
    endgenerate

endmodule

bind adc_evt_ctrl adc_evt_ctrl_chk #(.N(NUM_INST)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_rsp_vld (bus_rsp_vld),
    .bus_err     (bus_err),
    .bus_rdata   (bus_rdata),
    .inst_enable (inst_enable),
    .res_rdy     (res_rdy),
    .win_match   (win_match),
    .conv_start  (conv_start),
    .res_evt     (res_evt),
    .win_evt     (win_evt),
    .cfg_flat    (cfg_flat)
);

// File: tb/adc_evt_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_evt_ctrl_tb_top;

    localparam int N  = 4;
    localparam int VW = 1 + 4 + 8 + 32 + 1 + 32;
    localparam int NV = 12;

    // {wr, inst_enable, addr, wdata, exp_err, exp_rdata}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 4'h0, 8'h3C, 32'h0000_0000, 1'b0, 32'h0000_0000},  // R1 reset value
        {1'b1, 4'h0, 8'h3C, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},  // R2 write inst0
        {1'b0, 4'h0, 8'h3C, 32'h0000_0000, 1'b0, 32'h0000_0039},  // R3 only 0,3,4,5 kept
        {1'b1, 4'h0, 8'h5C, 32'h0000_0011, 1'b0, 32'h0000_0000},  // R2 inst1
        {1'b0, 4'h0, 8'h5C, 32'h0000_0000, 1'b0, 32'h0000_0011},  // R2
        {1'b1, 4'h2, 8'h5C, 32'h0000_0000, 1'b1, 32'h0000_0000},  // R4 locked write
        {1'b0, 4'h2, 8'h5C, 32'h0000_0000, 1'b0, 32'h0000_0011},  // R4/R5 unchanged, read ok
        {1'b0, 4'h0, 8'h40, 32'h0000_0000, 1'b1, 32'h0000_0000},  // R5 unmapped read
        {1'b1, 4'h0, 8'h7D, 32'h0000_0001, 1'b1, 32'h0000_0000},  // R5 misaligned write
        {1'b1, 4'h0, 8'h9C, 32'h0000_0028, 1'b0, 32'h0000_0000},  // R2 inst3
        {1'b0, 4'h0, 8'h9C, 32'h0000_0000, 1'b0, 32'h0000_0028},  // R2
        {1'b0, 4'h0, 8'h3C, 32'h0000_0000, 1'b0, 32'h0000_0039}   // R11 inst0 untouched
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rsp_vld;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic [N-1:0] inst_enable = '0;
    logic [N-1:0] start_raw = '0;
    logic [N-1:0] conv_start;
    logic [N-1:0] res_rdy = '0;
    logic [N-1:0] win_match = '0;
    logic [N-1:0] res_evt;
    logic [N-1:0] win_evt;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #4 clk = ~clk;

    adc_evt_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rsp_vld (bus_rsp_vld), .bus_rdata (bus_rdata), .bus_err (bus_err),
        .inst_enable (inst_enable), .start_raw (start_raw), .conv_start (conv_start),
        .res_rdy (res_rdy), .win_match (win_match), .res_evt (res_evt), .win_evt (win_evt)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called on a falling edge; returns on the falling edge where the response is due
    task automatic bus_xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                            output logic e, output logic [31:0] r);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        chk(bus_rsp_vld == 1'b1, "R2 rsp_vld", 32'(bus_rsp_vld), 32'd1);
        e = bus_err; r = bus_rdata;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input string tag);
        logic        e;
        logic [31:0] r;
        bus_xfer(1'b1, a, d, e, r);
        chk(e == 1'b0, tag, 32'(e), 32'd0);
    endtask

    task automatic watch_start(input int idx, input int fire_at, input string tag);
        for (int c = 1; c <= 6; c++) begin
            @(posedge clk); @(negedge clk);
            chk(conv_start[idx] == (c == fire_at), tag, 32'(conv_start[idx]), 32'(c == fire_at));
        end
    endtask

    task automatic ev_check(input int idx, input logic r, input logic w,
                            input logic er, input logic ew, input string tag);
        res_rdy[idx] = r; win_match[idx] = w;
        @(posedge clk); @(negedge clk);
        chk(res_evt[idx] == er, tag, 32'(res_evt[idx]), 32'(er));
        chk(win_evt[idx] == ew, tag, 32'(win_evt[idx]), 32'(ew));
        res_rdy[idx] = 1'b0; win_match[idx] = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(res_evt[idx] == 1'b0, tag, 32'(res_evt[idx]), 32'd0);
        chk(win_evt[idx] == 1'b0, tag, 32'(win_evt[idx]), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 outputs idle after reset
        chk(conv_start == '0, "R1 conv_start", 32'(conv_start), 32'd0);
        chk(res_evt == '0,    "R1 res_evt",    32'(res_evt),    32'd0);
        chk(win_evt == '0,    "R1 win_evt",    32'(win_evt),    32'd0);
        chk(bus_rsp_vld == 0, "R1 rsp_vld",    32'(bus_rsp_vld), 32'd0);

        // Register vector table
        for (int v = 0; v < NV; v++) begin
            logic        wr, e;
            logic [31:0] r;
            wr          = VEC[v][VW-1];
            inst_enable = VEC[v][VW-2 -: 4];
            bus_xfer(wr, VEC[v][VW-6 -: 8], VEC[v][VW-14 -: 32], e, r);
            chk(e == VEC[v][32], $sformatf("R2/R4/R5 err vec %0d", v), 32'(e), 32'(VEC[v][32]));
            if (!wr) begin
                chk(r == VEC[v][31:0], $sformatf("R2/R3 rdata vec %0d", v), r, VEC[v][31:0]);
            end
        end
        inst_enable = '0;

        // R7 plain rising edge on instance 0
        cfg_write(8'h3C, 32'h01, "R7 cfg");
        start_raw[0] = 1'b1;
        watch_start(0, 3, "R7 rise");
        watch_start(0, 0, "R7 held high");
        start_raw[0] = 1'b0;
        watch_start(0, 0, "R7 fall");

        // R8 inverted trigger, re-arm with input low
        cfg_write(8'h3C, 32'h09, "R8 cfg");
        watch_start(0, 0, "R8 rearm no spurious");
        start_raw[0] = 1'b1;
        watch_start(0, 0, "R8 rise ignored");
        start_raw[0] = 1'b0;
        watch_start(0, 3, "R8 fall fires");

        // R6 trigger disabled
        cfg_write(8'h3C, 32'h08, "R6 cfg");
        start_raw[0] = 1'b1;
        watch_start(0, 0, "R6 no start");
        start_raw[0] = 1'b0;
        watch_start(0, 0, "R6 no start");

        // R11 instance 1 (enabled, not inverted) unaffected by instance 0
        start_raw[1] = 1'b1;
        watch_start(1, 3, "R11 inst1 start");
        chk(conv_start[0] == 1'b0, "R11 inst0 quiet", 32'(conv_start[0]), 32'd0);

        // R9 / R10 on instance 2
        cfg_write(8'h7C, 32'h10, "R9 cfg");
        ev_check(2, 1'b1, 1'b0, 1'b1, 1'b0, "R9 result on");
        ev_check(2, 1'b0, 1'b1, 1'b0, 1'b0, "R10 window off");
        cfg_write(8'h7C, 32'h20, "R10 cfg");
        ev_check(2, 1'b1, 1'b0, 1'b0, 1'b0, "R9 result off");
        ev_check(2, 1'b0, 1'b1, 1'b0, 1'b1, "R10 window on");
        ev_check(3, 1'b1, 1'b1, 1'b0, 1'b1, "R11 inst3 events");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule